// File: doc/BRIEF.md
# Multi-Stream Sequential Line Prefetcher

This block follows up to eight sequential access streams and sends cache-line prefetch requests ahead of the demand loads in each stream. The load unit reports every load miss with its full byte address. Software arms the next stream by pulsing an allocate command. The first unmatched miss after that command claims a free stream slot. The miss's byte offset inside its 128-byte line fixes the stream direction. The stream then runs up to four lines ahead of the demand line.

Each prefetch carries a line address. Prefetches only use request cycles that the demand path leaves idle. One counter, shared by all streams, tracks the prefetches still outstanding and holds them to twenty. The memory side returns one acknowledgement per completed prefetch, and each acknowledgement frees one slot in that counter. A stream stops once it has prefetched the last line of its 4 KB page, and its slot becomes free again.

Top module: `pf_stream_prefetcher`

## Requirements
- R1: After reset, `pfValid` is 0 and `pfInFlight` is 0, and no stream is active.
- R2: A miss that matches no active stream's expected line, and that arrives while no allocate command is pending, changes nothing: no prefetch follows.
- R3: The line address is `missAddr[31:7]`. When an allocate is pending, the next unmatched miss takes the lowest free slot. If `missAddr[6]` is 1, the stream ascends and its first prefetch is line L+1. If `missAddr[6]` is 0, the stream descends and its first prefetch is line L-1.
- R4: A newly allocated stream issues exactly four prefetches, one line apart in its direction, and then stops until its demand line advances.
- R5: A miss on a stream's next expected line moves that expected line one step and allows exactly one more prefetch, the next line in sequence.
- R6: No prefetch is issued in any cycle in which `demandReq` is 1.
- R7: `pfInFlight` rises by one for each cycle with `pfValid` and falls by one for each `pfAck`. It never exceeds 20, so no prefetch is issued while it is 20. An acknowledgement while it is 0 leaves it at 0.
- R8: When several streams can issue, one prefetch is granted per cycle. The grant goes round-robin in slot order, starting from the slot after the last one granted.
- R9: A stream deactivates right after it issues the last line of its 4 KB page in its direction (line bits [4:0] equal to 31 ascending, or 0 descending). Its slot becomes free for a later allocation.
- R10: At most eight streams are active. An allocating miss that finds no free slot creates no stream and causes no prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Software command: arm the next unmatched miss to start a stream |
| missValid | input | 1 | A demand load missed this cycle |
| missAddr | input | 32 | Byte address of the missing load |
| demandReq | input | 1 | A demand request owns the memory request port this cycle |
| pfValid | output | 1 | A prefetch request is issued this cycle |
| pfLineAddr | output | 25 | Line address of the issued prefetch |
| pfAck | input | 1 | One outstanding prefetch has completed |
| pfInFlight | output | 5 | Number of prefetches issued and not yet acknowledged |

## Verification
Faults in this block show up quickly at the ports. A wrong direction bit or expected-line register puts a wrong line on `pfLineAddr` in the first cycle after the allocating miss. A bad credit count shows up in the same burst: the stream stops early, or a fifth line appears. A broken round-robin pointer or in-flight counter shows up during the multi-stream saturation run. In that run the order of the grants and the cycle at which issuing stops at twenty are both fixed in advance. A slot that fails to die at a page edge shows up later, when a new stream cannot find a free slot.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int PF_STREAMS = 8;

  typedef struct packed {
    logic [PF_STREAMS-1:0] allocOh;
    logic [PF_STREAMS-1:0] issueOh;
  } pfStrobe_t;
endpackage

// File: rtl/pf_stream_dp.sv
module pf_stream_dp
  import pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int PAGE_BYTES = 4096,
  parameter int DEPTH      = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  missValid,
  input  logic [ADDR_W-1:0]                     missAddr,
  input  pfStrobe_t                             strobe,
  output logic [PF_STREAMS-1:0]                 matchVec,
  output logic [PF_STREAMS-1:0]                 freeVec,
  output logic [PF_STREAMS-1:0]                 eligVec,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  pfLine
);
  localparam int N      = PF_STREAMS;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int PG_W   = $clog2(PAGE_BYTES) - OFF_W;
  localparam int CRED_W = $clog2(DEPTH + 1);

  logic [LINE_W-1:0] missLine;
  logic              missAsc;
  logic              missEdge;
  logic              unusedLowBits;

  assign missLine      = missAddr[ADDR_W-1:OFF_W];
  assign missAsc       = missAddr[OFF_W-1];
  assign missEdge      = missAsc ? (&missLine[PG_W-1:0]) : (~|missLine[PG_W-1:0]);
  assign unusedLowBits = ^missAddr[OFF_W-2:0];

  logic [N-1:0]      activeQ, ascQ;
  logic [LINE_W-1:0] expLineQ [N];
  logic [LINE_W-1:0] pfNextQ  [N];
  logic [CRED_W-1:0] creditQ  [N];
  logic [CRED_W-1:0] creditNext [N];
  logic [N-1:0]      pfEdge;

  for (genvar g = 0; g < N; g++) begin : gStream
    assign matchVec[g] = activeQ[g] && missValid && (missLine == expLineQ[g]);
    assign freeVec[g]  = !activeQ[g];
    assign eligVec[g]  = activeQ[g] && (creditQ[g] != '0);
    assign pfEdge[g]   = ascQ[g] ? (&pfNextQ[g][PG_W-1:0]) : (~|pfNextQ[g][PG_W-1:0]);

    always_comb begin
      creditNext[g] = creditQ[g];
      if (matchVec[g] && !strobe.issueOh[g] && (creditQ[g] < CRED_W'(DEPTH)))
        creditNext[g] = creditQ[g] + 1'b1;
      else if (strobe.issueOh[g] && !matchVec[g])
        creditNext[g] = creditQ[g] - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeQ[g]  <= 1'b0;
        ascQ[g]     <= 1'b0;
        expLineQ[g] <= '0;
        pfNextQ[g]  <= '0;
        creditQ[g]  <= '0;
      end else if (strobe.allocOh[g]) begin
        activeQ[g]  <= !missEdge;
        ascQ[g]     <= missAsc;
        expLineQ[g] <= missAsc ? missLine + 1'b1 : missLine - 1'b1;
        pfNextQ[g]  <= missAsc ? missLine + 1'b1 : missLine - 1'b1;
        creditQ[g]  <= CRED_W'(DEPTH);
      end else begin
        creditQ[g] <= creditNext[g];
        if (matchVec[g])
          expLineQ[g] <= ascQ[g] ? expLineQ[g] + 1'b1 : expLineQ[g] - 1'b1;
        if (strobe.issueOh[g]) begin
          pfNextQ[g] <= ascQ[g] ? pfNextQ[g] + 1'b1 : pfNextQ[g] - 1'b1;
          if (pfEdge[g]) activeQ[g] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    pfLine = '0;
    for (int i = 0; i < N; i++)
      if (strobe.issueOh[i]) pfLine = pfLine | pfNextQ[i];
  end
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int MAX_INFLIGHT = 20
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              allocValid,
  input  logic                              missValid,
  input  logic                              demandReq,
  input  logic                              pfAck,
  input  logic [PF_STREAMS-1:0]             matchVec,
  input  logic [PF_STREAMS-1:0]             freeVec,
  input  logic [PF_STREAMS-1:0]             eligVec,
  output pfStrobe_t                         strobe,
  output logic [$clog2(MAX_INFLIGHT+1)-1:0] inFlight
);
  localparam int N     = PF_STREAMS;
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(MAX_INFLIGHT + 1);

  logic             pendQ;
  logic [IDX_W-1:0] ptrQ;
  logic [CNT_W-1:0] cntQ;
  logic             missUnmatched;
  logic             found;
  logic [IDX_W-1:0] pickIdx;
  logic             canIssue;

  assign missUnmatched = missValid && !(|matchVec);
  assign canIssue      = !demandReq && (cntQ < CNT_W'(MAX_INFLIGHT));

  always_comb begin
    strobe.allocOh = '0;
    if (missUnmatched && pendQ) begin
      for (int i = N - 1; i >= 0; i--)
        if (freeVec[i]) strobe.allocOh = N'(1) << i;
    end
  end

  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptrQ) + k) % N;
      if (!found && eligVec[idx]) begin
        found   = 1'b1;
        pickIdx = IDX_W'(idx);
      end
    end
    strobe.issueOh = (found && canIssue) ? (N'(1) << pickIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      ptrQ  <= '0;
      cntQ  <= '0;
    end else begin
      if (allocValid) pendQ <= 1'b1;
      else if (missUnmatched) pendQ <= 1'b0;
      if (|strobe.issueOh)
        ptrQ <= (pickIdx == IDX_W'(N - 1)) ? '0 : pickIdx + 1'b1;
      if ((|strobe.issueOh) && !(pfAck && cntQ != '0))
        cntQ <= cntQ + 1'b1;
      else if (!(|strobe.issueOh) && pfAck && cntQ != '0)
        cntQ <= cntQ - 1'b1;
    end
  end

  assign inFlight = cntQ;
endmodule

// File: rtl/pf_stream_prefetcher.sv
module pf_stream_prefetcher
  import pf_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int PAGE_BYTES   = 4096,
  parameter int DEPTH        = 4,
  parameter int MAX_INFLIGHT = 20
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 allocValid,
  input  logic                                 missValid,
  input  logic [ADDR_W-1:0]                    missAddr,
  input  logic                                 demandReq,
  output logic                                 pfValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] pfLineAddr,
  input  logic                                 pfAck,
  output logic [$clog2(MAX_INFLIGHT+1)-1:0]    pfInFlight
);
  pfStrobe_t             strobe;
  logic [PF_STREAMS-1:0] matchVec, freeVec, eligVec;

  pf_ctrl #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .missValid(missValid),
    .demandReq(demandReq), .pfAck(pfAck), .matchVec(matchVec), .freeVec(freeVec),
    .eligVec(eligVec), .strobe(strobe), .inFlight(pfInFlight)
  );

  pf_stream_dp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES),
                 .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr), .strobe(strobe),
    .matchVec(matchVec), .freeVec(freeVec), .eligVec(eligVec), .pfLine(pfLineAddr)
  );

  assign pfValid = |strobe.issueOh;
endmodule

// File: rtl/pf_stream_prefetcher_chk.sv
module pf_stream_prefetcher_chk #(
  parameter int NS           = 8,
  parameter int MAX_INFLIGHT = 20
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              demandReq,
  input logic                              pfValid,
  input logic                              pfAck,
  input logic [$clog2(MAX_INFLIGHT+1)-1:0] pfInFlight,
  input logic [NS-1:0]                     allocOh,
  input logic [NS-1:0]                     issueOh
);
  assert_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    pfInFlight <= ($clog2(MAX_INFLIGHT+1))'(MAX_INFLIGHT));

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pfInFlight == ($clog2(MAX_INFLIGHT+1))'(MAX_INFLIGHT)) |-> !pfValid);

  assert_demand_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    demandReq |-> !pfValid);

  assert_count_up_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfAck) |=> pfInFlight == $past(pfInFlight) + 1'b1);

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!pfValid && pfAck && pfInFlight != '0) |=> pfInFlight == $past(pfInFlight) - 1'b1);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!pfValid && pfInFlight == '0) |=> pfInFlight == '0);

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueOh));

  assert_single_alloc_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allocOh));
endmodule

bind pf_stream_prefetcher pf_stream_prefetcher_chk #(
  .NS(pf_pkg::PF_STREAMS), .MAX_INFLIGHT(MAX_INFLIGHT)
) u_chk (
  .clk(clk), .rstN(rstN), .demandReq(demandReq), .pfValid(pfValid), .pfAck(pfAck),
  .pfInFlight(pfInFlight), .allocOh(strobe.allocOh), .issueOh(strobe.issueOh)
);

// File: tb/pf_stream_prefetcher_tb.sv
`timescale 1ns/1ps
module pf_stream_prefetcher_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        demandReq = 1'b0;
  logic        pfValid;
  logic [24:0] pfLineAddr;
  logic        pfAck = 1'b0;
  logic [4:0]  pfInFlight;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pf_stream_prefetcher u_dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .missValid(missValid),
    .missAddr(missAddr), .demandReq(demandReq), .pfValid(pfValid),
    .pfLineAddr(pfLineAddr), .pfAck(pfAck), .pfInFlight(pfInFlight)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sendAlloc();
    allocValid = 1'b1; tick(); allocValid = 1'b0;
  endtask

  task automatic sendMiss(input int line, input bit upper);
    missAddr = (32'(line) << 7) | (upper ? 32'h40 : 32'h10);
    missValid = 1'b1; tick(); missValid = 1'b0;
  endtask

  task automatic expectLine(input int line, input string req);
    #1;
    check(pfValid === 1'b1 && int'(pfLineAddr) == line, req, int'(pfLineAddr), line);
    tick();
  endtask

  task automatic expectIdle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      #1;
      check(pfValid === 1'b0, req, int'(pfValid), 0);
      tick();
    end
  endtask

  task automatic expectCount(input int n, input string req);
    #1;
    check(int'(pfInFlight) == n, req, int'(pfInFlight), n);
  endtask

  task automatic ackCycles(input int n);
    pfAck = 1'b1;
    for (int i = 0; i < n; i++) tick();
    pfAck = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check(pfValid === 1'b0, "R1 pfValid", int'(pfValid), 0);
    expectCount(0, "R1 inFlight");
  endtask

  task automatic testIgnoredMiss();
    sendMiss(32'h0A0, 1'b1);
    expectIdle(4, "R2 unarmed miss");
  endtask

  task automatic testAscending();
    sendAlloc();
    sendMiss(32'h100, 1'b1);
    for (int i = 1; i <= 4; i++) expectLine(32'h100 + i, "R3/R4 ascending");
    expectIdle(3, "R4 depth limit");
    expectCount(4, "R7 count after burst");
  endtask

  task automatic testAdvance();
    sendMiss(32'h101, 1'b0);
    expectLine(32'h105, "R5 advance");
    expectIdle(2, "R5 single extra");
    expectCount(5, "R7 count after advance");
    ackCycles(5);
    expectCount(0, "R7 drained");
    ackCycles(1);
    expectCount(0, "R7 no underflow");
  endtask

  task automatic testDescendingDemand();
    demandReq = 1'b1;
    sendAlloc();
    sendMiss(32'h210, 1'b0);
    expectIdle(3, "R6 demand wins");
    demandReq = 1'b0;
    for (int i = 1; i <= 4; i++) expectLine(32'h210 - i, "R3 descending");
    expectIdle(1, "R4 descending depth");
    ackCycles(4);
    expectCount(0, "R7 drained desc");
  endtask

  task automatic testPageEdge();
    sendAlloc();
    sendMiss(32'h31E, 1'b1);
    expectLine(32'h31F, "R9 last line of page");
    expectIdle(3, "R9 stops at page edge");
    sendMiss(32'h31F, 1'b1);
    expectIdle(3, "R9 dead stream no advance");
    ackCycles(1);
    expectCount(0, "R7 drained page");
  endtask

  task automatic testCapAndRoundRobin();
    demandReq = 1'b1;
    for (int s = 0; s < 6; s++) begin
      sendAlloc();
      sendMiss(32'h400 + 32'h100 * s, 1'b1);
    end
    demandReq = 1'b0;
    for (int i = 0; i < 20; i++) begin
      int s;
      s = ((i % 6) + 1) % 6;
      expectLine(32'h400 + 32'h100 * s + (i / 6) + 1, "R8 round-robin order");
    end
    expectIdle(2, "R7 cap holds");
    expectCount(20, "R7 at cap");
    ackCycles(1);
    expectLine(32'h704, "R7 ack frees one slot");
    expectCount(20, "R7 back at cap");
  endtask

  task automatic testNoFreeSlot();
    int n;
    n = 0;
    pfAck = 1'b1;
    while ((pfInFlight != 0 || pfValid) && n < 100) begin
      tick();
      n++;
    end
    pfAck = 1'b0;
    expectCount(0, "R7 full drain");
    expectIdle(2, "R4 all credits spent");
    sendAlloc();
    sendMiss(32'hA00, 1'b1);
    expectIdle(4, "R10 no ninth stream");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testIgnoredMiss();
    testAscending();
    testAdvance();
    testDescendingDemand();
    testPageEdge();
    testCapAndRoundRobin();
    testNoFreeSlot();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule